// File: doc/BRIEF.md
# Adaptive Sinusoid Tracker with Quadrature Outputs

This block follows one sampled sinusoid and keeps three coupled estimates of it: its amplitude, its frequency and its angle. Each accepted sample is compared with the in-phase wave the block produced for the previous sample. That reconstruction error then steers all three estimates through forward-Euler updates. The result acts as a band-pass filter whose centre follows the input. It rebuilds a clean in-phase wave and the matching wave shifted by a quarter period, with no separate filter stage.

Three copies can serve the three phases of a grid. A fourth copy, fed with a derived signal, can report magnitude and angle directly from its amplitude and angle outputs. All gains are run-time inputs that are already scaled by the sample period. Sine and cosine come from a table built at elaboration. With default parameters the angle is a 16-bit accumulator where 65536 counts make one full turn. Frequency is held as a phase step per sample with 8 extra fraction bits. The sample rate is 6400 samples/s and the nominal frequency is 50 Hz.

Top module: `epll_estimator`

## Requirements
- R1: While `rst_n` is low, `est_valid`, `amp_out`, `angle_out`, `inphase_out` and `quad_out` read 0 and `freq_out` reads the nominal step, 131072 for 50 Hz at 6400 samples/s (step = f·2^24/fs).
- R2: `est_valid` is high exactly in the cycle after a cycle with `smp_valid` high. In a cycle with `smp_valid` low, no output changes at the next edge, whatever `smp_in` and the gains do.
- R3: On each accepted sample the angle becomes θ + (ω >>> 8) − ((kp·e·sin θ) >>> 31), modulo 2^16. Here e is the stored error, sin θ is the table value at the old angle, and every shift is arithmetic. With kp = 0 the angle advances by exactly ω >>> 8.
- R4: On each accepted sample the amplitude state (8 fraction bits) grows by (k·e·cos θ) >>> 23. `amp_out` is that state >>> 8. With k = 0 `amp_out` does not change.
- R5: On each accepted sample the frequency state becomes ω − ((ki·e·sin θ) >>> 23), clamped to [ω_nom/2, 3·ω_nom/2], which is [65536, 196608] by default. With ki = 0 it does not change.
- R6: The error stored with a sample is `smp_in` minus the in-phase output before that sample. The states use it only at the next accepted sample. After reset, the first sample therefore leaves the amplitude at 0 for any gain.
- R7: The outputs use the updated amplitude A (integer part) and the updated angle. `inphase_out` = (A·cos) >>> 15 and `quad_out` = −((A·sin) >>> 15). The table holds 256 entries, round(32767·sin(2π·i/256)), indexed by angle bits [15:8]. Cosine reads index + 64, modulo 256.
- R8: The amplitude state saturates to the signed 24-bit range, so `amp_out` stays within [−32768, 32767] under extreme inputs and gains.
- R9: For a steady sinusoid of amplitude 16000 with k = 2048, kp = 1700 and ki = 24, the magnitude of `amp_out` settles within 2000 of 16000. `freq_out` settles within 3 % of the step for the input frequency: 50 Hz, and afterwards 52 Hz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | A new sample is present on `smp_in` |
| smp_in | input | 16 | Signed input sample |
| gain_k | input | 16 | Amplitude gain, unsigned, pre-scaled |
| gain_kp | input | 16 | Angle gain, unsigned, pre-scaled |
| gain_ki | input | 16 | Frequency gain, unsigned, pre-scaled |
| est_valid | output | 1 | Outputs updated from the previous cycle's sample |
| inphase_out | output | 16 | Signed reconstructed in-phase wave |
| quad_out | output | 16 | Signed quadrature wave |
| amp_out | output | 16 | Signed amplitude estimate, integer part |
| freq_out | output | 24 | Signed frequency as phase step per sample, 8 fraction bits |
| angle_out | output | 16 | Angle estimate, 2^16 counts per turn |

## Verification
On one accepted sample, two things happen at the same edge. The new error is captured, and the states are updated with the error from the sample before. A one-sample slip between these two paths shows up at once as a wrong amplitude after the first sample after reset. It also appears as a drift from the reference in every tracking run. A run of extreme samples with full-scale gains drives the amplitude and frequency clamps while the angle wraps in the same cycles. A behavioural reference model in the bench is compared with every output on every clock, so clamp handling and wrap handling are judged together.

// File: rtl/epll_pkg.sv
package epll_pkg;

    localparam real TWO_PI = 6.28318530717958647692;

    // Sine by odd power series, folded to [-pi, pi] first
    function automatic real series_sine(input real x_in);
        real x;
        real term;
        real acc;
        x = x_in;
        while (x > TWO_PI / 2.0) x = x - TWO_PI;
        while (x < -TWO_PI / 2.0) x = x + TWO_PI;
        term = x;
        acc  = x;
        for (int n = 1; n <= 12; n++) begin
            term = -term * x * x / real'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Rounded table code for entry idx of a 2^depth_log2 entry full-turn table
    function automatic int sine_code(input int idx, input int depth_log2, input int peak);
        real s;
        s = series_sine(TWO_PI * real'(idx) / real'(1 << depth_log2)) * real'(peak);
        if (s >= 0.0) return $rtoi(s + 0.5);
        return -$rtoi(0.5 - s);
    endfunction

    // Nominal phase step per sample, scaled by 2^bits, rounded
    function automatic longint nominal_step(input longint nom_hz, input longint smp_hz,
                                            input int bits);
        return ((nom_hz <<< bits) + smp_hz / 2) / smp_hz;
    endfunction

endpackage

// File: rtl/epll_sine_rom.sv
module epll_sine_rom #(
    parameter int TBL_LOG2 = 8,
    parameter int DATA_W   = 16
) (
    input  logic [TBL_LOG2-1:0]      index_i,
    output logic signed [DATA_W-1:0] sin_o,
    output logic signed [DATA_W-1:0] cos_o
);
    localparam int DEPTH = 1 << TBL_LOG2;
    localparam int PEAK  = (1 << (DATA_W - 1)) - 1;
    localparam logic [TBL_LOG2-1:0] QUARTER = TBL_LOG2'(DEPTH / 4);

    logic signed [DATA_W-1:0] table_w [DEPTH];
    logic [TBL_LOG2-1:0]      cos_idx;

    generate
        for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
            localparam int CODE = epll_pkg::sine_code(gi, TBL_LOG2, PEAK);
            assign table_w[gi] = DATA_W'(CODE);
        end
    endgenerate

    assign cos_idx = index_i + QUARTER;
    assign sin_o   = table_w[index_i];
    assign cos_o   = table_w[cos_idx];

endmodule

// File: rtl/epll_state_step.sv
module epll_state_step #(
    parameter int     DATA_W    = 16,
    parameter int     GAIN_W    = 16,
    parameter int     PHASE_W   = 16,
    parameter int     AMP_FRAC  = 8,
    parameter int     FREQ_FRAC = 8,
    parameter longint FREQ_MIN  = 65536,
    parameter longint FREQ_MAX  = 196608
) (
    input  logic signed [DATA_W:0]               err_i,
    input  logic signed [DATA_W-1:0]             sin_i,
    input  logic signed [DATA_W-1:0]             cos_i,
    input  logic signed [DATA_W+AMP_FRAC-1:0]    amp_i,
    input  logic signed [PHASE_W+FREQ_FRAC-1:0]  freq_i,
    input  logic [PHASE_W-1:0]                   phase_i,
    input  logic [GAIN_W-1:0]                    gain_k_i,
    input  logic [GAIN_W-1:0]                    gain_kp_i,
    input  logic [GAIN_W-1:0]                    gain_ki_i,
    output logic signed [DATA_W+AMP_FRAC-1:0]    amp_o,
    output logic signed [PHASE_W+FREQ_FRAC-1:0]  freq_o,
    output logic [PHASE_W-1:0]                   phase_o
);
    localparam int ERR_W   = DATA_W + 1;
    localparam int AMP_W   = DATA_W + AMP_FRAC;
    localparam int MUL1_W  = GAIN_W + 1 + ERR_W;
    localparam int PROD_W  = MUL1_W + DATA_W;
    localparam int UNIT_SH = GAIN_W + DATA_W - 1;
    localparam int AMP_SH  = UNIT_SH - AMP_FRAC;
    localparam int FREQ_SH = UNIT_SH - FREQ_FRAC;

    localparam logic signed [PROD_W-1:0] AMP_HI  = PROD_W'((longint'(1) <<< (AMP_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] AMP_LO  = -AMP_HI - PROD_W'(1);
    localparam logic signed [PROD_W-1:0] FREQ_HI = PROD_W'(FREQ_MAX);
    localparam logic signed [PROD_W-1:0] FREQ_LO = PROD_W'(FREQ_MIN);

    // gain x error x trig value, full precision
    function automatic logic signed [PROD_W-1:0] gain_prod(
        input logic [GAIN_W-1:0]        g,
        input logic signed [ERR_W-1:0]  e,
        input logic signed [DATA_W-1:0] t
    );
        logic signed [MUL1_W-1:0] m;
        m = MUL1_W'($signed({1'b0, g})) * MUL1_W'(e);
        return PROD_W'(m) * PROD_W'(t);
    endfunction

    logic signed [PROD_W-1:0] prod_amp;
    logic signed [PROD_W-1:0] prod_ang;
    logic signed [PROD_W-1:0] prod_frq;
    logic signed [PROD_W-1:0] sum_amp;
    logic signed [PROD_W-1:0] sum_frq;
    logic [PHASE_W-1:0]       nominal_adv;
    logic [PHASE_W-1:0]       correction;

    always_comb begin
        prod_amp = gain_prod(gain_k_i, err_i, cos_i);
        prod_ang = gain_prod(gain_kp_i, err_i, sin_i);
        prod_frq = gain_prod(gain_ki_i, err_i, sin_i);

        // amplitude: grow along cosine of old angle, saturate
        sum_amp = PROD_W'(amp_i) + (prod_amp >>> AMP_SH);
        if (sum_amp > AMP_HI)      amp_o = AMP_W'(AMP_HI);
        else if (sum_amp < AMP_LO) amp_o = AMP_W'(AMP_LO);
        else                       amp_o = AMP_W'(sum_amp);

        // frequency: pulled by sine of old angle, kept inside the band
        sum_frq = PROD_W'(freq_i) - (prod_frq >>> FREQ_SH);
        if (sum_frq > FREQ_HI)      freq_o = (PHASE_W + FREQ_FRAC)'(FREQ_HI);
        else if (sum_frq < FREQ_LO) freq_o = (PHASE_W + FREQ_FRAC)'(FREQ_LO);
        else                        freq_o = (PHASE_W + FREQ_FRAC)'(sum_frq);

        // angle: old frequency step minus proportional correction, wraps
        nominal_adv = PHASE_W'(freq_i >>> FREQ_FRAC);
        correction  = PHASE_W'(prod_ang >>> UNIT_SH);
        phase_o     = phase_i + nominal_adv - correction;
    end

endmodule

// File: rtl/epll_estimator.sv
module epll_estimator #(
    parameter int     DATA_W     = 16,
    parameter int     GAIN_W     = 16,
    parameter int     PHASE_W    = 16,
    parameter int     TBL_LOG2   = 8,
    parameter int     AMP_FRAC   = 8,
    parameter int     FREQ_FRAC  = 8,
    parameter longint SAMPLE_HZ  = 6400,
    parameter longint NOMINAL_HZ = 50
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               smp_valid,
    input  logic signed [DATA_W-1:0]           smp_in,
    input  logic [GAIN_W-1:0]                  gain_k,
    input  logic [GAIN_W-1:0]                  gain_kp,
    input  logic [GAIN_W-1:0]                  gain_ki,
    output logic                               est_valid,
    output logic signed [DATA_W-1:0]           inphase_out,
    output logic signed [DATA_W-1:0]           quad_out,
    output logic signed [DATA_W-1:0]           amp_out,
    output logic signed [PHASE_W+FREQ_FRAC-1:0] freq_out,
    output logic [PHASE_W-1:0]                 angle_out
);
    localparam int     ERR_W    = DATA_W + 1;
    localparam int     AMP_W    = DATA_W + AMP_FRAC;
    localparam int     FREQ_W   = PHASE_W + FREQ_FRAC;
    localparam int     MULT_W   = 2 * DATA_W;
    localparam longint FREQ_NOM = epll_pkg::nominal_step(NOMINAL_HZ, SAMPLE_HZ, FREQ_W);
    localparam longint FREQ_MIN = FREQ_NOM / 2;
    localparam longint FREQ_MAX = FREQ_NOM + FREQ_NOM / 2;

    typedef struct packed {
        logic signed [ERR_W-1:0]  err;
        logic signed [AMP_W-1:0]  amp;
        logic signed [FREQ_W-1:0] freq;
        logic [PHASE_W-1:0]       phase;
        logic signed [DATA_W-1:0] inph;
        logic signed [DATA_W-1:0] quad;
        logic                     vld;
    } est_state_t;

    localparam est_state_t ST_RESET = '{
        err:   '0,
        amp:   '0,
        freq:  FREQ_W'(FREQ_NOM),
        phase: '0,
        inph:  '0,
        quad:  '0,
        vld:   1'b0
    };

    est_state_t st_d;
    est_state_t st_q;

    logic signed [DATA_W-1:0] sin_now;
    logic signed [DATA_W-1:0] cos_now;
    logic signed [DATA_W-1:0] sin_nx;
    logic signed [DATA_W-1:0] cos_nx;
    logic signed [AMP_W-1:0]  amp_nx;
    logic signed [FREQ_W-1:0] freq_nx;
    logic [PHASE_W-1:0]       phase_nx;
    logic signed [DATA_W-1:0] amp_int_nx;
    logic signed [MULT_W-1:0] prod_inph;
    logic signed [MULT_W-1:0] prod_quad;

    // trig values at the stored angle drive the state update
    epll_sine_rom #(
        .TBL_LOG2 (TBL_LOG2),
        .DATA_W   (DATA_W)
    ) u_rom_now (
        .index_i (st_q.phase[PHASE_W-1 -: TBL_LOG2]),
        .sin_o   (sin_now),
        .cos_o   (cos_now)
    );

    epll_state_step #(
        .DATA_W    (DATA_W),
        .GAIN_W    (GAIN_W),
        .PHASE_W   (PHASE_W),
        .AMP_FRAC  (AMP_FRAC),
        .FREQ_FRAC (FREQ_FRAC),
        .FREQ_MIN  (FREQ_MIN),
        .FREQ_MAX  (FREQ_MAX)
    ) u_step (
        .err_i     (st_q.err),
        .sin_i     (sin_now),
        .cos_i     (cos_now),
        .amp_i     (st_q.amp),
        .freq_i    (st_q.freq),
        .phase_i   (st_q.phase),
        .gain_k_i  (gain_k),
        .gain_kp_i (gain_kp),
        .gain_ki_i (gain_ki),
        .amp_o     (amp_nx),
        .freq_o    (freq_nx),
        .phase_o   (phase_nx)
    );

    // trig values at the updated angle build the outputs
    epll_sine_rom #(
        .TBL_LOG2 (TBL_LOG2),
        .DATA_W   (DATA_W)
    ) u_rom_next (
        .index_i (phase_nx[PHASE_W-1 -: TBL_LOG2]),
        .sin_o   (sin_nx),
        .cos_o   (cos_nx)
    );

    always_comb begin
        amp_int_nx = DATA_W'(amp_nx >>> AMP_FRAC);
        prod_inph  = MULT_W'(amp_int_nx) * MULT_W'(cos_nx);
        prod_quad  = MULT_W'(amp_int_nx) * MULT_W'(sin_nx);

        st_d     = st_q;
        st_d.vld = smp_valid;
        if (smp_valid) begin
            st_d.err   = ERR_W'(smp_in) - ERR_W'(st_q.inph);
            st_d.amp   = amp_nx;
            st_d.freq  = freq_nx;
            st_d.phase = phase_nx;
            st_d.inph  = DATA_W'(prod_inph >>> (DATA_W - 1));
            st_d.quad  = DATA_W'(-(prod_quad >>> (DATA_W - 1)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign est_valid   = st_q.vld;
    assign inphase_out = st_q.inph;
    assign quad_out    = st_q.quad;
    assign amp_out     = DATA_W'(st_q.amp >>> AMP_FRAC);
    assign freq_out    = st_q.freq;
    assign angle_out   = st_q.phase;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> est_valid);                                        // R2
    AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !est_valid);                                      // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(angle_out) && $stable(amp_out) && $stable(freq_out)
                        && $stable(inphase_out) && $stable(quad_out)));  // R2
    AST_ANGLE_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && gain_kp == '0) |=>
        angle_out == PHASE_W'($past(angle_out) + PHASE_W'($past(freq_out) >>> FREQ_FRAC))); // R3
    AST_AMP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && gain_k == '0) |=> amp_out == $past(amp_out));      // R4
    AST_FREQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && gain_ki == '0) |=> freq_out == $past(freq_out));   // R5
    AST_FREQ_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(freq_out) >= FREQ_MIN) && (longint'(freq_out) <= FREQ_MAX)); // R5

endmodule

// File: tb/test_epll_estimator.sv
module test_epll_estimator;

    localparam longint W_NOM  = 131072;
    localparam longint W_LO   = 65536;
    localparam longint W_HI   = 196608;
    localparam longint A_HI   = (longint'(1) <<< 23) - 1;
    localparam longint A_LO   = -(longint'(1) <<< 23);
    localparam real    TWO_PI = 6.28318530717958647692;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               vld_drv = 1'b0;
    logic signed [15:0] u_drv = '0;
    logic [15:0]        g_k = '0;
    logic [15:0]        g_kp = '0;
    logic [15:0]        g_ki = '0;
    logic               est_valid;
    logic signed [15:0] inphase_out;
    logic signed [15:0] quad_out;
    logic signed [15:0] amp_out;
    logic signed [23:0] freq_out;
    logic [15:0]        angle_out;

    int     checks = 0;
    int     errors = 0;
    bit     done = 1'b0;
    longint tb_sin [256];
    longint m_e, m_a, m_w, m_th, m_v, m_q;
    bit     m_vld;
    int     amp_clamps = 0;
    int     freq_clamps = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    epll_estimator i_epll_estimator (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (vld_drv),
        .smp_in      (u_drv),
        .gain_k      (g_k),
        .gain_kp     (g_kp),
        .gain_ki     (g_ki),
        .est_valid   (est_valid),
        .inphase_out (inphase_out),
        .quad_out    (quad_out),
        .amp_out     (amp_out),
        .freq_out    (freq_out),
        .angle_out   (angle_out)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_true(input string tag, input string what, input bit ok,
                            input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint sin_at(input longint th);
        return tb_sin[int'((th >>> 8) & 255)];
    endfunction

    function automatic longint cos_at(input longint th);
        return tb_sin[int'(((th >>> 8) + 64) & 255)];
    endfunction

    function automatic longint rnd(input real x);
        if (x >= 0.0) return longint'($rtoi(x + 0.5));
        return -longint'($rtoi(0.5 - x));
    endfunction

    task automatic model_sample(input longint u);
        longint s, c, pa, pp, pw, na, nw, nth, ai;
        s  = sin_at(m_th);
        c  = cos_at(m_th);
        pa = longint'(g_k) * m_e * c;
        pp = longint'(g_kp) * m_e * s;
        pw = longint'(g_ki) * m_e * s;
        na = m_a + (pa >>> 23);
        if (na > A_HI) begin na = A_HI; amp_clamps++; end
        if (na < A_LO) begin na = A_LO; amp_clamps++; end
        nw = m_w - (pw >>> 23);
        if (nw > W_HI) begin nw = W_HI; freq_clamps++; end
        if (nw < W_LO) begin nw = W_LO; freq_clamps++; end
        nth = (m_th + (m_w >>> 8) - (pp >>> 31)) & 65535;
        m_e  = u - m_v;
        m_a  = na;
        m_w  = nw;
        m_th = nth;
        ai   = na >>> 8;
        m_v  = (ai * cos_at(nth)) >>> 15;
        m_q  = -((ai * sin_at(nth)) >>> 15);
        m_vld = 1'b1;
    endtask

    task automatic compare_all();
        chk("R2", "est_valid", longint'(est_valid), longint'(m_vld));
        chk("R7", "inphase_out", longint'(inphase_out), m_v);
        chk("R7", "quad_out", longint'(quad_out), m_q);
        chk("R4", "amp_out", longint'(amp_out), m_a >>> 8);
        chk("R5", "freq_out", longint'(freq_out), m_w);
        chk("R3", "angle_out", longint'(angle_out), m_th);
    endtask

    // called at a falling edge; leaves at the next falling edge
    task automatic step_in(input bit v, input longint u);
        vld_drv = v;
        u_drv   = 16'(u);
        if (v) model_sample(u);
        else   m_vld = 1'b0;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic next_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            summary();
        end
    end

    initial begin
        longint a_save, w_save, th_save, v_save, q_save, mag;
        real    ph;
        for (int i = 0; i < 256; i++) tb_sin[i] = rnd(32767.0 * $sin(TWO_PI * real'(i) / 256.0));
        m_e = 0; m_a = 0; m_w = W_NOM; m_th = 0; m_v = 0; m_q = 0; m_vld = 1'b0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "est_valid", longint'(est_valid), 0);
        chk("R1", "amp_out", longint'(amp_out), 0);
        chk("R1", "angle_out", longint'(angle_out), 0);
        chk("R1", "freq_out", longint'(freq_out), W_NOM);
        chk("R1", "inphase_out", longint'(inphase_out), 0);
        chk("R1", "quad_out", longint'(quad_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: first sample has a zero stored error, amplitude stays 0
        g_k = 16'd40000; g_kp = 16'd1700; g_ki = 16'd24;
        step_in(1'b1, 20000);
        chk("R6", "amp after first sample", longint'(amp_out), 0);
        chk("R3", "angle after first sample", longint'(angle_out), 512);
        step_in(1'b1, 20000);
        chk_true("R6", "amp after second sample nonzero", amp_out != 0, longint'(amp_out), 1);

        // R2: idle cycles with changing inputs and gains leave everything alone
        a_save = longint'(amp_out); w_save = longint'(freq_out); th_save = longint'(angle_out);
        v_save = longint'(inphase_out); q_save = longint'(quad_out);
        for (int i = 0; i < 5; i++) begin
            next_lfsr();
            g_k = lfsr; g_kp = ~lfsr; g_ki = lfsr ^ 16'h5A5A;
            step_in(1'b0, longint'($signed(lfsr)));
        end
        chk("R2", "amp held", longint'(amp_out), a_save);
        chk("R2", "freq held", longint'(freq_out), w_save);
        chk("R2", "angle held", longint'(angle_out), th_save);
        chk("R2", "inphase held", longint'(inphase_out), v_save);
        chk("R2", "quad held", longint'(quad_out), q_save);

        // R9: lock on a 50 Hz wave, with idle gaps between samples
        rst_n = 1'b0;
        @(negedge clk);
        m_e = 0; m_a = 0; m_w = W_NOM; m_th = 0; m_v = 0; m_q = 0; m_vld = 1'b0;
        rst_n = 1'b1;
        g_k = 16'd2048; g_kp = 16'd1700; g_ki = 16'd24;
        ph = 0.3;
        for (int n = 0; n < 3000; n++) begin
            step_in(1'b1, rnd(16000.0 * $cos(ph)));
            ph = ph + TWO_PI * 50.0 / 6400.0;
            if (n % 3 == 2) begin
                next_lfsr();
                step_in(1'b0, longint'($signed(lfsr)));
            end
        end
        mag = (amp_out < 0) ? -longint'(amp_out) : longint'(amp_out);
        chk_true("R9", "amplitude at 50 Hz", mag > 14000 && mag < 18000, mag, 16000);
        chk_true("R9", "frequency at 50 Hz",
                 longint'(freq_out) > W_NOM - 3900 && longint'(freq_out) < W_NOM + 3900,
                 longint'(freq_out), W_NOM);

        // R9: step to 52 Hz
        for (int n = 0; n < 3000; n++) begin
            step_in(1'b1, rnd(16000.0 * $cos(ph)));
            ph = ph + TWO_PI * 52.0 / 6400.0;
        end
        mag = (amp_out < 0) ? -longint'(amp_out) : longint'(amp_out);
        chk_true("R9", "amplitude at 52 Hz", mag > 14000 && mag < 18000, mag, 16000);
        chk_true("R9", "frequency at 52 Hz",
                 longint'(freq_out) > 136315 - 4000 && longint'(freq_out) < 136315 + 4000,
                 longint'(freq_out), 136315);

        // R3 R4 R5: zero gains freeze amplitude and frequency, angle free-runs
        g_k = '0; g_kp = '0; g_ki = '0;
        for (int n = 0; n < 20; n++) begin
            a_save = longint'(amp_out); w_save = longint'(freq_out); th_save = longint'(angle_out);
            next_lfsr();
            step_in(1'b1, longint'($signed(lfsr)));
            chk("R4", "amp with k=0", longint'(amp_out), a_save);
            chk("R5", "freq with ki=0", longint'(freq_out), w_save);
            chk("R3", "angle with kp=0", longint'(angle_out), (th_save + (w_save >>> 8)) & 65535);
        end

        // R8 R5: extreme samples and full gains drive both clamps
        g_k = 16'hFFFF; g_kp = 16'd300; g_ki = 16'hFFFF;
        for (int n = 0; n < 300; n++) begin
            next_lfsr();
            step_in(1'b1, lfsr[0] ? 32767 : -32768);
            chk_true("R5", "freq inside band",
                     longint'(freq_out) >= W_LO && longint'(freq_out) <= W_HI,
                     longint'(freq_out), W_NOM);
        end
        chk_true("R8", "amplitude clamp reached", amp_clamps > 0, amp_clamps, 1);
        chk_true("R5", "frequency clamp reached", freq_clamps > 0, freq_clamps, 1);

        done = 1'b1;
        summary();
    end

endmodule